// File: doc/BRIEF.md
# RS485 Transceiver Direction Controller

This block sits next to a UART serializer and deserializer and owns the driver-enable pin of a half-duplex RS485 transceiver. When a character is written into the transmit buffer, the block first turns the line driver on. It then waits one full bit time before it lets the serializer place the start bit. After the transmit buffer and the shift register have both drained, it keeps the driver on for one more bit time. All guard timing is counted on the same one-cycle baud tick that paces the serializer, so the guard tracks any baud-rate change.

The block raises a transmission-complete flag and an optional interrupt at the moment the last stop bit has left the shift register. That moment depends only on the transmitter's empty strobes. A per-burst echo option chooses between two receiver behaviours. In echo mode the receiver stays enabled, so the transmitted characters come back through the receive path. In blanked mode the receiver is switched off for the burst. It is switched back on in the same cycle the completion flag is set, which is before the driver is released. At that moment a one-cycle flush strobe tells the receive side to discard its FIFO contents, its latched error and status flags, and any half-sampled frame. Software clears the completion flag by writing one. A new character written to the transmit buffer also clears it. A character written during the trailing guard bit resumes the burst with no gap in the driver enable and no second leading guard.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After the first write of an idle period, the driver enable `de_o` rises on a baud tick. The transmit permission `tx_go_o` rises on the next baud tick, which is exactly one bit time (GUARD_BITS ticks, default 1) later. `tx_go_o` is never high while `de_o` is low.
- R2: `de_o` falls exactly one bit time after the baud tick that ends the final stop bit, where the final stop bit ends when both the transmit buffer and the shift register report empty.
- R3: `tc_o` rises one clock after both empty strobes are seen high with no write in the same cycle. Its timing is the same whether or not the receiver is blanked.
- R4: `irq_o` is high exactly when `tc_o` is high and `tc_irq_en_i` is high.
- R5: With `echo_en_i` low at the first write of a burst, `rx_en_o` is low for every cycle in which a character is being shifted out.
- R6: In a blanked burst, `rx_en_o` returns high in the same cycle that `tc_o` rises. This happens before `de_o` falls.
- R7: `rx_flush_o` pulses for one cycle at each completion of a blanked burst, together with the return of `rx_en_o`. It never pulses in an echo burst.
- R8: With `echo_en_i` high at the first write of a burst, `rx_en_o` stays high throughout the burst.
- R9: A write during the trailing guard keeps `de_o` and `tx_go_o` high with no gap. The new character is sent with no second leading guard.
- R10: `tc_o` clears one clock after `tc_clear_i` is pulsed, and one clock after a write to the transmit buffer.
- R11: The guard lengths in R1 and R2 follow the baud-tick period, whatever that period is.
- R12: Out of reset, `de_o`, `tx_go_o`, `tc_o`, `irq_o` and `rx_flush_o` are low and `rx_enable` (`rx_en_o`) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle strobe per bit time, shared with the serializer |
| tx_write_i | input | 1 | A character is written into the transmit buffer this cycle |
| tx_buf_empty_i | input | 1 | Transmit data buffer is empty |
| tx_shift_empty_i | input | 1 | Shift register is idle, with the stop bit fully sent |
| echo_en_i | input | 1 | 1: receiver hears own transmission; 0: receiver blanked during bursts |
| tc_clear_i | input | 1 | Write-one-to-clear strobe for the completion flag |
| tc_irq_en_i | input | 1 | Completion interrupt enable |
| de_o | output | 1 | Transceiver driver enable |
| tx_go_o | output | 1 | Serializer may start or continue shifting characters |
| tc_o | output | 1 | Transmission-complete flag |
| irq_o | output | 1 | Completion interrupt |
| rx_en_o | output | 1 | Receiver enable |
| rx_flush_o | output | 1 | One-cycle strobe: drop receive FIFO, latched flags and partial frame |

## Verification
Bursts are run with one, two and three queued characters, with both echo settings, with and without a write landing in the trailing guard, and with a baud-tick period that changes from burst to burst between 4 and 12 clocks. Varying the tick period separates guards that are truly counted in bit times from guards that are fixed in clock cycles. The echo setting separates a completion path that stands apart from the receiver from one that waits on it. A write during the trailing guard separates a continued burst from a released-and-restarted one. Directed flag clears by software and by a new write, with the interrupt enable both on and off, cover the flag and interrupt behaviour.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // line released
    ST_ARM,     // write seen, waiting for a tick boundary
    ST_LEAD,    // driver on, leading guard
    ST_ACTIVE,  // serializer running
    ST_TRAIL    // drained, trailing guard
  } dir_state_e;

  function automatic logic line_driven(dir_state_e s);
    return (s == ST_LEAD) || (s == ST_ACTIVE) || (s == ST_TRAIL);
  endfunction

  function automatic logic rx_blank_window(dir_state_e s);
    return (s == ST_ARM) || (s == ST_LEAD) || (s == ST_ACTIVE);
  endfunction

endpackage

// File: rtl/rs485_guard_fsm.sv
module rs485_guard_fsm
  import rs485_dir_pkg::*;
#(
  parameter int unsigned GUARD_BITS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       tx_write_i,
  input  logic       tx_drained_i,
  output dir_state_e state_o,
  output logic       start_o,
  output logic       done_o,
  output logic       de_o,
  output logic       tx_go_o
);

  localparam int unsigned CW = (GUARD_BITS > 1) ? $clog2(GUARD_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(GUARD_BITS - 1);

  dir_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic guard_end;

  assign guard_end = baud_tick_i && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (tx_write_i) begin
        state_d = ST_ARM;
        start_o = 1'b1;
      end
      ST_ARM: if (baud_tick_i) begin
        state_d = ST_LEAD;
        cnt_d   = '0;
      end
      ST_LEAD: if (baud_tick_i) begin
        if (guard_end) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACTIVE: if (!tx_write_i && tx_drained_i) begin
        state_d = ST_TRAIL;
        cnt_d   = '0;
        done_o  = 1'b1;
      end
      ST_TRAIL: begin
        if (tx_write_i) begin
          state_d = ST_ACTIVE;   // resume, no new leading guard
        end else if (baud_tick_i) begin
          if (guard_end) state_d = ST_IDLE;
          else           cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign de_o    = line_driven(state_q);
  assign tx_go_o = (state_q == ST_ACTIVE) || (state_q == ST_TRAIL);

  AST_LEAD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> $past(baud_tick_i)); // R1
  AST_GO_AFTER_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_go_o) |-> $past(de_o)); // R1
  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(de_o) |-> $past(baud_tick_i) && !$past(tx_write_i)); // R2

endmodule

// File: rtl/rs485_tc_flag.sv
module rs485_tc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic write_i,
  input  logic clear_i,
  output logic tc_o
);

  logic tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tc_q <= 1'b0;
    else if (set_i)             tc_q <= 1'b1;
    else if (write_i || clear_i) tc_q <= 1'b0;
  end

  assign tc_o = tc_q;

  AST_TC_CLR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_i |=> !tc_o); // R10
  AST_TC_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !set_i) |=> !tc_o); // R10

endmodule

// File: rtl/rs485_rx_gate.sv
module rs485_rx_gate
  import rs485_dir_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  dir_state_e state_i,
  input  logic       echo_en_i,
  input  logic       start_i,
  input  logic       done_i,
  output logic       rx_en_o,
  output logic       rx_flush_o
);

  logic blank_q;
  logic flush_q;

  // echo choice is fixed per burst at its first write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (start_i) blank_q <= !echo_en_i;
      flush_q <= done_i && blank_q;
    end
  end

  assign rx_en_o    = !(blank_q && rx_blank_window(state_i));
  assign rx_flush_o = flush_q;

  AST_FLUSH_WITH_RX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |-> rx_en_o); // R7
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |=> !rx_flush_o); // R7

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int unsigned GUARD_BITS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_tick_i,
  input  logic tx_write_i,
  input  logic tx_buf_empty_i,
  input  logic tx_shift_empty_i,
  input  logic echo_en_i,
  input  logic tc_clear_i,
  input  logic tc_irq_en_i,
  output logic de_o,
  output logic tx_go_o,
  output logic tc_o,
  output logic irq_o,
  output logic rx_en_o,
  output logic rx_flush_o
);

  dir_state_e state;
  logic burst_start;
  logic burst_done;
  logic drained;

  assign drained = tx_buf_empty_i && tx_shift_empty_i;

  rs485_guard_fsm #(.GUARD_BITS(GUARD_BITS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_tick_i  (baud_tick_i),
    .tx_write_i   (tx_write_i),
    .tx_drained_i (drained),
    .state_o      (state),
    .start_o      (burst_start),
    .done_o       (burst_done),
    .de_o         (de_o),
    .tx_go_o      (tx_go_o)
  );

  rs485_tc_flag u_tc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (burst_done),
    .write_i (tx_write_i),
    .clear_i (tc_clear_i),
    .tc_o    (tc_o)
  );

  rs485_rx_gate u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .echo_en_i  (echo_en_i),
    .start_i    (burst_start),
    .done_i     (burst_done),
    .rx_en_o    (rx_en_o),
    .rx_flush_o (rx_flush_o)
  );

  assign irq_o = tc_o && tc_irq_en_i;

  AST_TC_ONLY_WHEN_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |-> $past(tx_buf_empty_i && tx_shift_empty_i)); // R3
  AST_RX_BACK_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(de_o) |-> rx_en_o); // R6
  AST_RX_BACK_WITH_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> tc_o); // R6

endmodule

// File: tb/rs485_dir_ctrl_test.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, tx_write = 1'b0, buf_empty = 1'b1, shift_empty = 1'b1;
  logic echo_en = 1'b0, tc_clear = 1'b0, irq_en = 1'b0;
  logic de_o, tx_go_o, tc_o, irq_o, rx_en_o, rx_flush_o;

  always #2 clk = ~clk;  // 250 MHz

  rs485_dir_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .tx_write_i(tx_write),
    .tx_buf_empty_i(buf_empty), .tx_shift_empty_i(shift_empty),
    .echo_en_i(echo_en), .tc_clear_i(tc_clear), .tc_irq_en_i(irq_en),
    .de_o(de_o), .tx_go_o(tx_go_o), .tc_o(tc_o), .irq_o(irq_o),
    .rx_en_o(rx_en_o), .rx_flush_o(rx_flush_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus / serializer model state
  int period = 6, tick_cnt = 0, buf_cnt = 0, bitcnt = 0, chars_sent = 0;
  int wr_pending = 0, clr_pending = 0;
  bit shifting = 0, trail_wr_arm = 0, echo_mode = 0;
  // measurements
  int de_rise_c, go_rise_c, de_fall_c, stop_end_c, tc_rise_c, rxen_rise_c;
  int de_falls, go_rises, tc_rises, flushes, rx_bad, irq_bad;
  bit de_s = 0, go_s = 0, tc_s = 0, rx_s = 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lead_expect(int per);
    return per;  // one bit time = one tick period
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (de_o && !de_s && de_rise_c < 0) de_rise_c = cyc;
    if (!de_o && de_s) begin de_fall_c = cyc; de_falls++; end
    if (tx_go_o && !go_s) begin go_rises++; if (go_rise_c < 0) go_rise_c = cyc; end
    if (tc_o && !tc_s) begin
      tc_rises++; tc_rise_c = cyc;
      if (trail_wr_arm && de_o) begin wr_pending++; trail_wr_arm = 0; end
    end
    if (rx_en_o && !rx_s) rxen_rise_c = cyc;
    if (rx_flush_o) flushes++;
    if (echo_mode ? !rx_en_o : (shifting && rx_en_o)) rx_bad++;
    if (irq_o != (tc_o && irq_en)) irq_bad++;
    de_s = de_o; go_s = tx_go_o; tc_s = tc_o; rx_s = rx_en_o;
    // serializer: start bit + 8 data + stop = 10 ticks
    if (shifting && tick) begin
      bitcnt++;
      if (bitcnt == 10) begin shifting = 0; stop_end_c = cyc; end
    end
    if (!shifting && tx_go_o && buf_cnt > 0) begin
      shifting = 1; bitcnt = 0; buf_cnt--; chars_sent++;
    end
    if (wr_pending > 0) begin tx_write = 1; buf_cnt++; wr_pending--; end
    else tx_write = 0;
    tc_clear = (clr_pending > 0);
    if (clr_pending > 0) clr_pending--;
    if (tick_cnt >= period - 1) begin tick_cnt = 0; tick = 1; end
    else begin tick_cnt++; tick = 0; end
    buf_empty = (buf_cnt == 0);
    shift_empty = !shifting;
  end

  task automatic run_burst(int per, bit echo, int nch, bit ien, bit twr, bit do_clr);
    bit tc_before;
    int guard;
    @(posedge clk); #1;
    period = per; echo_en = echo; echo_mode = echo; irq_en = ien;
    de_rise_c = -1; go_rise_c = -1; de_fall_c = -1; stop_end_c = -1;
    tc_rise_c = -1; rxen_rise_c = -1;
    de_falls = 0; go_rises = 0; tc_rises = 0; flushes = 0; rx_bad = 0; irq_bad = 0;
    chars_sent = 0; trail_wr_arm = twr;
    tc_before = tc_o;
    wr_pending = nch;
    if (tc_before) begin
      repeat (3) @(negedge clk);
      #1 check(tc_o == 1'b0, "R10 tc cleared by write", tc_o, 0);
    end
    guard = 0;
    while (!(de_falls > 0 && !de_o && buf_cnt == 0 && !shifting && wr_pending == 0) && guard < 6000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 6000) check(0, "R1 burst timeout", guard, 0);
    repeat (2) @(negedge clk); #1;
    check(go_rise_c - de_rise_c == lead_expect(per), "R1 R11 lead guard", go_rise_c - de_rise_c, per);
    check(de_fall_c - stop_end_c == per, "R2 R11 trail guard", de_fall_c - stop_end_c, per);
    check(tc_rise_c - stop_end_c == 1, "R3 tc timing", tc_rise_c - stop_end_c, 1);
    check(tc_o == 1'b1, "R3 tc held", tc_o, 1);
    check(irq_bad == 0, "R4 irq mismatch cycles", irq_bad, 0);
    check(chars_sent == nch + int'(twr), "R9 chars sent", chars_sent, nch + int'(twr));
    if (twr) begin
      check(de_falls == 1, "R9 de stays high across trail write", de_falls, 1);
      check(go_rises == 1, "R9 no second lead", go_rises, 1);
    end
    if (!echo) begin
      check(rx_bad == 0, "R5 rx enabled while shifting", rx_bad, 0);
      check(rxen_rise_c == tc_rise_c, "R6 rx back with tc", rxen_rise_c, tc_rise_c);
      check(rxen_rise_c < de_fall_c, "R6 rx back before release", rxen_rise_c, de_fall_c - 1);
      check(flushes == tc_rises, "R7 flush per completion", flushes, tc_rises);
    end else begin
      check(rx_bad == 0, "R8 rx dropped in echo", rx_bad, 0);
      check(flushes == 0, "R8 R7 no flush in echo", flushes, 0);
    end
    if (do_clr) begin
      @(posedge clk); #1 clr_pending = 1;
      repeat (3) @(negedge clk); #1;
      check(tc_o == 1'b0, "R10 w1c clear", tc_o, 0);
      check(irq_o == 1'b0, "R4 irq follows clear", irq_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd485));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(de_o == 0, "R12 reset de", de_o, 0);
    check(tx_go_o == 0, "R12 reset go", tx_go_o, 0);
    check(tc_o == 0 && irq_o == 0, "R12 reset tc/irq", tc_o, 0);
    check(rx_en_o == 1 && rx_flush_o == 0, "R12 reset rx", rx_en_o, 1);
    repeat (10) @(negedge clk);
    run_burst(4, 0, 1, 1, 0, 0);
    run_burst(8, 1, 2, 1, 0, 1);
    run_burst(5, 0, 1, 0, 1, 0);
    run_burst(12, 1, 1, 1, 1, 1);
    run_burst(6, 0, 3, 1, 1, 1);
    for (int i = 0; i < 20; i++) begin
      run_burst(int'($urandom_range(12, 4)), 1'($urandom_range(1, 0)),
                int'($urandom_range(3, 1)), 1'($urandom_range(1, 0)),
                1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      repeat (int'($urandom_range(20, 1))) @(negedge clk);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule